// File: doc/BRIEF.md
# Coordinated CPU-GPU Voltage-Frequency Governor

This block is the decision stage of a run-time energy manager for a die where a CPU and a GPU share one power and thermal budget. At the end of every control interval it receives a one-cycle tick. With that tick come two one-bit sensitivity classes, each saying whether one unit's performance responds strongly to its own clock. A small coupling degree comes with them as well. The block then moves each unit's operating-point index by at most one step, following a four-way decision matrix.

The matrix works like this. When only the GPU is sensitive, budget moves toward the GPU. When only the CPU is sensitive, budget moves toward the CPU. When both are sensitive, both are steered toward balanced middle levels. When neither is sensitive, both are lowered. The CPU index is confined to the software-selectable part of its ladder. The slowest CPU state it may reach is a floor. A build parameter picks one of two policies for that floor: it is fixed at a middle rung, or it goes deeper when coupling between the units is weak. A strobe marks each interval in which either index actually moved.

Top module: `dvfs_governor`

## Requirements
- R1: During and after reset, before any tick, `cpu_pstate` is 2 (the fastest software state), `gpu_level` is 2 (high) and `state_changed` is 0. The CPU ladder, fastest to slowest, is index 0 and 1 (boost, never produced), then 2, 3, 4, 5, 6. The GPU encoding is 0 = low, 1 = medium, 2 = high.
- R2: In a cycle without `tick`, neither index changes, and `state_changed` is 0 in the following cycle.
- R3: On a tick with `gpu_sens_hi`=1 and `cpu_sens_hi`=0, the GPU level rises by one, saturating at 2. The CPU index rises by one (slower), saturating at the floor.
- R4: On a tick with both sensitivities at 1, each index moves one step toward its balanced value: GPU 1, CPU 3. If an index is already there, it stays.
- R5: On a tick with `gpu_sens_hi`=0 and `cpu_sens_hi`=1, the GPU level falls by one, saturating at 0. The CPU index falls by one (faster), saturating at 2.
- R6: On a tick with both sensitivities at 0, the GPU level falls by one, saturating at 0. The CPU index rises by one, saturating at the floor.
- R7: With `MULTILEVEL`=0, the CPU floor is index 4 for every coupling value.
- R8: With `MULTILEVEL`=1, the CPU floor is 6 minus the smaller of `coupling` and 2. So coupling 0 gives 6, coupling 1 gives 5, and 2 or 3 give 4.
- R9: On a tick where the current CPU index is slower than the current floor, the CPU index falls by exactly one, whatever the sensitivity classes. The GPU still follows its class rule.
- R10: The CPU index always stays within 2..6 and the GPU level within 0..2. Neither moves by more than one per tick.
- R11: `state_changed` is 1 for exactly the one cycle after a tick that changed either index, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | End of control interval, one cycle |
| cpu_sens_hi | input | 1 | CPU frequency sensitivity is high |
| gpu_sens_hi | input | 1 | GPU frequency sensitivity is high |
| coupling | input | CPL_W (2) | Performance-coupling degree |
| cpu_pstate | output | 3 | CPU operating-point index, 2 fastest, 6 slowest |
| gpu_level | output | 2 | GPU level, 0 low, 1 medium, 2 high |
| state_changed | output | 1 | One-cycle strobe: an index moved on the last tick |

## Verification
The floor clamp and the class step can fall on the same tick. This happens when a higher coupling value arrives together with the tick while the CPU sits at a rung the new floor forbids. The bench provokes it by driving reductions at coupling 0 until the CPU reaches index 6, then ticking with coupling 2 under every class. It also lets a pseudo-random sweep mix coupling changes with all four classes on two builds, one per floor policy. Each tick is judged against an arithmetic model: the clamp takes precedence and moves the CPU by exactly one rung, while the GPU still follows its class.

// File: rtl/dvfs_gov_pkg.sv
package dvfs_gov_pkg;
   // move class indexed by {gpu_sens_hi, cpu_sens_hi}
   typedef enum logic [1:0] {
      MV_REDUCE  = 2'b00,
      MV_TO_CPU  = 2'b01,
      MV_TO_GPU  = 2'b10,
      MV_BALANCE = 2'b11
   } power_move_e;
endpackage

// File: rtl/dvfs_cpu_floor.sv
module dvfs_cpu_floor #(
   parameter int CPU_STATES   = 7,
   parameter int SINGLE_FLOOR = 4,
   parameter bit MULTILEVEL   = 1'b1,
   parameter int CPL_W        = 2,
   localparam int IW          = $clog2(CPU_STATES)
) (
   input  logic [CPL_W-1:0] coupling,
   output logic [IW-1:0]    floor_idx
);
   localparam int LAST = CPU_STATES - 1;
   localparam int SPAN = LAST - SINGLE_FLOOR;

   generate
      if (MULTILEVEL) begin : g_multi
         // weak coupling lets the CPU go deeper
         always_comb begin
            if (int'(coupling) >= SPAN) floor_idx = IW'(SINGLE_FLOOR);
            else                        floor_idx = IW'(LAST - int'(coupling));
         end
      end else begin : g_single
         logic unused_cpl;
         assign unused_cpl = ^coupling;
         assign floor_idx  = IW'(SINGLE_FLOOR);
      end
   endgenerate
endmodule

// File: rtl/dvfs_cpu_step.sv
module dvfs_cpu_step
   import dvfs_gov_pkg::*;
#(
   parameter int CPU_STATES = 7,
   parameter int FIRST_SW   = 2,
   parameter int BAL_CPU    = 3,
   localparam int IW        = $clog2(CPU_STATES)
) (
   input  logic [IW-1:0] cur,
   input  logic [IW-1:0] floor_idx,
   input  power_move_e   move,
   output logic [IW-1:0] nxt
);
   logic [IW-1:0] target;

   always_comb begin
      target = (IW'(BAL_CPU) > floor_idx) ? floor_idx : IW'(BAL_CPU);
      if (cur > floor_idx) begin
         nxt = cur - 1'b1;
      end else begin
         unique case (move)
            MV_TO_GPU, MV_REDUCE: nxt = (cur < floor_idx) ? cur + 1'b1 : cur;
            MV_TO_CPU:            nxt = (cur > IW'(FIRST_SW)) ? cur - 1'b1 : cur;
            MV_BALANCE: begin
               if (cur < target)      nxt = cur + 1'b1;
               else if (cur > target) nxt = cur - 1'b1;
               else                   nxt = cur;
            end
            default:              nxt = cur;
         endcase
      end
   end
endmodule

// File: rtl/dvfs_gpu_step.sv
module dvfs_gpu_step
   import dvfs_gov_pkg::*;
#(
   parameter int GPU_LEVELS = 3,
   parameter int BAL_GPU    = 1,
   localparam int GW        = $clog2(GPU_LEVELS)
) (
   input  logic [GW-1:0] cur,
   input  power_move_e   move,
   output logic [GW-1:0] nxt
);
   localparam int TOP = GPU_LEVELS - 1;

   always_comb begin
      unique case (move)
         MV_TO_GPU:            nxt = (cur < GW'(TOP)) ? cur + 1'b1 : cur;
         MV_TO_CPU, MV_REDUCE: nxt = (cur != '0) ? cur - 1'b1 : cur;
         MV_BALANCE: begin
            if (cur < GW'(BAL_GPU))      nxt = cur + 1'b1;
            else if (cur > GW'(BAL_GPU)) nxt = cur - 1'b1;
            else                         nxt = cur;
         end
         default:              nxt = cur;
      endcase
   end
endmodule

// File: rtl/dvfs_governor.sv
module dvfs_governor
   import dvfs_gov_pkg::*;
#(
   parameter int CPU_STATES   = 7,
   parameter int FIRST_SW     = 2,
   parameter int SINGLE_FLOOR = 4,
   parameter int BAL_CPU      = 3,
   parameter int GPU_LEVELS   = 3,
   parameter int BAL_GPU      = 1,
   parameter bit MULTILEVEL   = 1'b1,
   parameter int CPL_W        = 2,
   localparam int IW          = $clog2(CPU_STATES),
   localparam int GW          = $clog2(GPU_LEVELS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             cpu_sens_hi,
   input  logic             gpu_sens_hi,
   input  logic [CPL_W-1:0] coupling,
   output logic [IW-1:0]    cpu_pstate,
   output logic [GW-1:0]    gpu_level,
   output logic             state_changed
);
   localparam int LAST = CPU_STATES - 1;

   initial begin
      assert (FIRST_SW <= SINGLE_FLOOR && SINGLE_FLOOR <= LAST)
         else $fatal(1, "floor outside software range");
      assert (BAL_CPU >= FIRST_SW && BAL_CPU <= LAST)
         else $fatal(1, "CPU balance point outside range");
      assert (BAL_GPU >= 0 && BAL_GPU < GPU_LEVELS)
         else $fatal(1, "GPU balance point outside range");
   end

   power_move_e   move;
   logic [IW-1:0] floor_idx, cpu_nxt, cpu_q;
   logic [GW-1:0] gpu_nxt, gpu_q;
   logic          chg_q;

   assign move = power_move_e'({gpu_sens_hi, cpu_sens_hi});

   dvfs_cpu_floor #(
      .CPU_STATES(CPU_STATES), .SINGLE_FLOOR(SINGLE_FLOOR),
      .MULTILEVEL(MULTILEVEL), .CPL_W(CPL_W)
   ) u_floor (.coupling(coupling), .floor_idx(floor_idx));

   dvfs_cpu_step #(
      .CPU_STATES(CPU_STATES), .FIRST_SW(FIRST_SW), .BAL_CPU(BAL_CPU)
   ) u_cpu (.cur(cpu_q), .floor_idx(floor_idx), .move(move), .nxt(cpu_nxt));

   dvfs_gpu_step #(
      .GPU_LEVELS(GPU_LEVELS), .BAL_GPU(BAL_GPU)
   ) u_gpu (.cur(gpu_q), .move(move), .nxt(gpu_nxt));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cpu_q <= IW'(FIRST_SW);
         gpu_q <= GW'(GPU_LEVELS - 1);
         chg_q <= 1'b0;
      end else if (tick) begin
         cpu_q <= cpu_nxt;
         gpu_q <= gpu_nxt;
         chg_q <= (cpu_nxt != cpu_q) || (gpu_nxt != gpu_q);
      end else begin
         chg_q <= 1'b0;
      end
   end

   assign cpu_pstate    = cpu_q;
   assign gpu_level     = gpu_q;
   assign state_changed = chg_q;

   // R2: indices hold between ticks
   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> ($stable(cpu_q) && $stable(gpu_q)));
   // R11: strobe only follows a tick
   p_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
      state_changed |-> $past(tick));
   // R10: CPU index stays in the software range
   p_cpu_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_q >= IW'(FIRST_SW)) && (cpu_q <= IW'(LAST)));
   // R10: at most one step per tick
   p_cpu_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> ((cpu_q == $past(cpu_q)) || (cpu_q == $past(cpu_q) + 1'b1)
                || (cpu_q + 1'b1 == $past(cpu_q))));
   p_gpu_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> ((gpu_q == $past(gpu_q)) || (gpu_q == $past(gpu_q) + 1'b1)
                || (gpu_q + 1'b1 == $past(gpu_q))));
   // R9: an index slower than the floor is pulled one rung faster
   p_floor_pull_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && (cpu_q > floor_idx)) |=> (cpu_q + 1'b1 == $past(cpu_q)));
endmodule

// File: tb/tb_dvfs_governor.sv
module tb_dvfs_governor;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       cpu_hi = 1'b0;
   logic       gpu_hi = 1'b0;
   logic [1:0] cpl = 2'd0;
   logic [2:0] cpu_m, cpu_s;
   logic [1:0] gpu_m, gpu_s;
   logic       chg_m, chg_s;

   int errors = 0;
   int checks = 0;
   int mc, mg, sc, sg;   // models: multilevel and single-level builds

   always #10 clk = ~clk;   // 50 MHz

   dvfs_governor #(.MULTILEVEL(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .cpu_sens_hi(cpu_hi),
      .gpu_sens_hi(gpu_hi), .coupling(cpl), .cpu_pstate(cpu_m),
      .gpu_level(gpu_m), .state_changed(chg_m));

   dvfs_governor #(.MULTILEVEL(1'b0)) dut_single (
      .clk(clk), .rst_n(rst_n), .tick(tick), .cpu_sens_hi(cpu_hi),
      .gpu_sens_hi(gpu_hi), .coupling(cpl), .cpu_pstate(cpu_s),
      .gpu_level(gpu_s), .state_changed(chg_s));

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   function automatic int floor_of(input bit multi, input int c);
      if (!multi) return 4;               // R7
      return 6 - ((c < 2) ? c : 2);       // R8
   endfunction

   function automatic int cpu_model(input int cur, input int fl, input int mv);
      int tgt;
      if (cur > fl) return cur - 1;       // R9
      case (mv)
         2, 0: return (cur < fl) ? cur + 1 : cur;   // R3, R6
         1:    return (cur > 2) ? cur - 1 : cur;    // R5
         default: begin                             // R4
            tgt = (3 > fl) ? fl : 3;
            return (cur < tgt) ? cur + 1 : (cur > tgt) ? cur - 1 : cur;
         end
      endcase
   endfunction

   function automatic int gpu_model(input int cur, input int mv);
      case (mv)
         2:       return (cur < 2) ? cur + 1 : cur;
         1, 0:    return (cur > 0) ? cur - 1 : cur;
         default: return (cur < 1) ? cur + 1 : (cur > 1) ? cur - 1 : cur;
      endcase
   endfunction

   function automatic string tag_of(input int mv, input bit above);
      if (above) return "R9";
      case (mv)
         2: return "R3";
         3: return "R4";
         1: return "R5";
         default: return "R6";
      endcase
   endfunction

   // one interval: tick cycle, result check, idle-cycle check
   task automatic interval(input bit g, input bit c, input int cp);
      int mv, nmc, nmg, nsc, nsg, fm, fs;
      bit am, as_;
      mv = {g, c};
      @(negedge clk);
      gpu_hi = g; cpu_hi = c; cpl = 2'(cp); tick = 1'b1;
      fm = floor_of(1'b1, cp); fs = floor_of(1'b0, cp);
      am = (mc > fm); as_ = (sc > fs);
      nmc = cpu_model(mc, fm, mv); nmg = gpu_model(mg, mv);
      nsc = cpu_model(sc, fs, mv); nsg = gpu_model(sg, mv);
      @(negedge clk);
      tick = 1'b0;
      chk({tag_of(mv, am), " multi cpu"}, int'(cpu_m), nmc);
      chk({tag_of(mv, am), " multi gpu"}, int'(gpu_m), nmg);
      chk({tag_of(mv, as_), " single cpu"}, int'(cpu_s), nsc);
      chk({tag_of(mv, as_), " single gpu"}, int'(gpu_s), nsg);
      chk("R11 multi strobe", int'(chg_m), int'((nmc != mc) || (nmg != mg)));
      chk("R11 single strobe", int'(chg_s), int'((nsc != sc) || (nsg != sg)));
      chk("R10 range", int'(cpu_m >= 3'd2 && cpu_s >= 3'd2 && cpu_s <= 3'd4), 1);
      mc = nmc; mg = nmg; sc = nsc; sg = nsg;
      @(negedge clk);
      chk("R2 hold cpu", int'(cpu_m), mc);
      chk("R2 hold gpu", int'(gpu_s), sg);
      chk("R2 strobe low", int'(chg_m | chg_s), 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
   end

   initial begin
      logic [7:0] lfsr;
      lfsr = 8'hA5;
      repeat (3) @(negedge clk);
      chk("R1 cpu reset", int'(cpu_m), 2);
      chk("R1 gpu reset", int'(gpu_m), 2);
      chk("R1 strobe reset", int'(chg_m | chg_s), 0);
      @(negedge clk) rst_n = 1'b1;
      mc = 2; mg = 2; sc = 2; sg = 2;
      repeat (2) @(negedge clk);
      chk("R1 cpu after reset", int'(cpu_s), 2);

      // R7/R8: dig to each floor
      for (int cp = 0; cp < 4; cp++) begin
         repeat (6) interval(1'b0, 1'b0, cp);
         chk("R8 multi floor", int'(cpu_m), floor_of(1'b1, cp));
         chk("R7 single floor", int'(cpu_s), 4);
         repeat (6) interval(1'b0, 1'b1, cp);   // R5 back to fastest
         chk("R5 fastest", int'(cpu_m), 2);
      end

      // R9: floor tightens on the same tick under every class
      for (int mv = 0; mv < 4; mv++) begin
         repeat (5) interval(1'b0, 1'b0, 0);
         interval(mv[1], mv[0], 2);
         interval(mv[1], mv[0], 3);
      end

      // sweep
      for (int i = 0; i < 400; i++) begin
         lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
         interval(lfsr[0], lfsr[1], int'(lfsr[3:2]));
      end
      finish_run();
   end
endmodule